// File: doc/BRIEF.md
# Processor exception entry sequencer

This block performs trap entry for a small 32-bit soft processor. The pipeline raises a one-cycle request with a cause code and supplies the current PC, the pending branch target, the delay-slot, immediate-prefix and prefixed-branch flags, the MMU fault classification and the current machine status word. On the next clock edge the block commits the new PC, a link-register write (index and value), an updated status word and updated exception status, exception address and branch target registers.

The return address in the link write depends on the cause. An MMU fault rewinds it so that the interrupted branch, or its immediate prefix, executes again. Every entry saves the translation and user-mode bits into their saved copies one position higher and then clears them. An MMU fault that arrives while an earlier MMU fault is still being handled is reported on a fatal output, and so is an unknown cause code. Neither of these changes any state. The handler signals the end of MMU fault handling with a one-cycle return pulse.

Top module: `trap_entry_seq`

## Requirements
- R1: While reset is active and after its release, `pc_o`, `msr_o`, `esr_o`, `ear_o`, `btr_o`, `link_val_o`, `link_sel_o` and all pulse outputs read zero until the first accepted request.
- R2: Cause 0 (hardware exception) writes PC+4 to link register 17, sets PC to 0x20 and sets status bit 9 (exception in progress).
- R3: Cause 1 (MMU fault) writes to link register 17 the PC reduced by 4 when the delay-slot flag is set, by 8 when delay-slot and prefixed-branch are both set, by 4 when only the immediate-prefix flag is set, and unreduced otherwise. It sets PC to 0x20 and sets status bit 9.
- R4: For causes 0 and 1, exception-status bit 12 becomes the delay-slot flag. When that flag is set, the branch target register loads `btarget_i`; otherwise it holds.
- R5: Every accepted entry copies status bit 13 into bit 14 and bit 11 into bit 12, clears bits 13 and 11, and keeps all other bits of `msr_i` unless R2, R3, R6, R7 or R8 name them.
- R6: Cause 2 (external interrupt) writes the PC to link register 14, sets PC to 0x10 and clears status bit 1, leaving bit 9 as supplied.
- R7: Cause 3 (hardware break) writes the PC to link register 16, sets status bit 3 and sets PC to 0x18.
- R8: Cause 4 (software break) sets status bit 3 and PC to `btarget_i` with no link write.
- R9: On an MMU fault the exception status becomes 16 plus 2 when `fault_miss_i` is set, plus 1 when the access is a fetch (`fault_acc_i`=2). Bit 10 is set for a store (`fault_acc_i`=1), and `fault_addr_i` is latched into `ear_o`.
- R10: An MMU fault requested after an accepted MMU fault and before a `mmu_ret_i` pulse raises `fatal_o` for one cycle and leaves every register and `entry_o` unchanged.
- R11: With parameter EXC_EN at 0, a cause-0 request produces no entry, no fatal and no state change.
- R12: A cause code of 5 to 7 raises `fatal_o` for one cycle without changing any register.
- R13: All updates of an accepted request appear one clock after the request, together with one-cycle `entry_o` and `flags_clr_o` pulses that instruct the pipeline to clear its delay-slot and immediate-prefix flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle trap request |
| cause_i | input | 3 | Cause: 0 hw exception, 1 MMU fault, 2 interrupt, 3 hw break, 4 sw break |
| pc_i | input | 32 | PC of the interrupted instruction |
| btarget_i | input | 32 | Pending branch target |
| dslot_i | input | 1 | Instruction sits in a delay slot |
| imm_i | input | 1 | Instruction carries an immediate prefix |
| bimm_i | input | 1 | Branch before the delay slot was prefixed |
| fault_miss_i | input | 1 | MMU fault kind: 1 miss, 0 protection |
| fault_acc_i | input | 2 | Access: 0 load, 1 store, 2 fetch |
| fault_addr_i | input | 32 | Faulting address |
| msr_i | input | 32 | Current machine status word |
| mmu_ret_i | input | 1 | MMU fault handler has finished |
| entry_o | output | 1 | Entry committed this cycle |
| pc_o | output | 32 | New PC |
| link_we_o | output | 1 | Link register write enable |
| link_sel_o | output | 5 | Link register index |
| link_val_o | output | 32 | Link register value |
| msr_o | output | 32 | Updated status word |
| esr_o | output | 32 | Exception status register |
| ear_o | output | 32 | Exception address register |
| btr_o | output | 32 | Branch target register |
| flags_clr_o | output | 1 | Clear delay-slot and prefix flags |
| fatal_o | output | 1 | Nested MMU fault or unknown cause |

## Verification
The state hardest to reach from the ports is the nested MMU fault. It needs an accepted MMU fault and then, with no return pulse in between, a second MMU request. The bench keeps the return pulse away across one directed pair for exactly this reason. It then checks that the fatal pulse appears and that the address, status and PC outputs still hold the first fault's values. The rewind of the return address under a prefixed branch in a delay slot is reached by raising all three flag combinations on MMU requests in the vector table. A second instance built with exception support off covers the ignored hardware exception.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int LR_W = 5;

  localparam logic [2:0] C_HWEXC = 3'd0;
  localparam logic [2:0] C_MMU   = 3'd1;
  localparam logic [2:0] C_IRQ   = 3'd2;
  localparam logic [2:0] C_HWBRK = 3'd3;
  localparam logic [2:0] C_SWBRK = 3'd4;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  // status word bit positions; saved copies sit one above the live bits
  localparam int ST_IE  = 1;
  localparam int ST_BIP = 3;
  localparam int ST_EIP = 9;
  localparam int ST_UM  = 11;
  localparam int ST_UMS = 12;
  localparam int ST_VM  = 13;
  localparam int ST_VMS = 14;

  localparam int ES_STORE = 10;
  localparam int ES_DSLOT = 12;

  localparam logic [LR_W-1:0] LR_EXC = 5'd17;
  localparam logic [LR_W-1:0] LR_IRQ = 5'd14;
  localparam logic [LR_W-1:0] LR_BRK = 5'd16;
endpackage

// File: rtl/trap_link_calc.sv
module trap_link_calc
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      cause_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            dslot_i,
  input  logic            imm_i,
  input  logic            bimm_i,
  output logic            we_o,
  output logic [LR_W-1:0] sel_o,
  output logic [XLEN-1:0] val_o
);
  logic [1:0] rewind;

  always_comb begin
    rewind = 2'd0;
    if (dslot_i)    rewind = bimm_i ? 2'd2 : 2'd1;
    else if (imm_i) rewind = 2'd1;
  end

  always_comb begin
    we_o  = 1'b0;
    sel_o = '0;
    val_o = pc_i;
    unique case (cause_i)
      C_HWEXC: begin
        we_o  = 1'b1;
        sel_o = LR_EXC;
        val_o = pc_i + XLEN'(4);
      end
      C_MMU: begin
        we_o  = 1'b1;
        sel_o = LR_EXC;
        val_o = pc_i - (XLEN'(rewind) << 2);
      end
      C_IRQ: begin
        we_o  = 1'b1;
        sel_o = LR_IRQ;
      end
      C_HWBRK: begin
        we_o  = 1'b1;
        sel_o = LR_BRK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_msr_calc.sv
module trap_msr_calc
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      cause_i,
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] msr_o
);
  always_comb begin
    msr_o         = msr_i;
    msr_o[ST_VMS] = msr_i[ST_VM];
    msr_o[ST_UMS] = msr_i[ST_UM];
    msr_o[ST_VM]  = 1'b0;
    msr_o[ST_UM]  = 1'b0;
    unique case (cause_i)
      C_HWEXC, C_MMU:   msr_o[ST_EIP] = 1'b1;
      C_IRQ:            msr_o[ST_IE]  = 1'b0;
      C_HWBRK, C_SWBRK: msr_o[ST_BIP] = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_esr_calc.sv
module trap_esr_calc
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      cause_i,
  input  logic [XLEN-1:0] esr_q_i,
  input  logic            dslot_i,
  input  logic            miss_i,
  input  logic [1:0]      acc_i,
  output logic [XLEN-1:0] esr_o
);
  always_comb begin
    esr_o = esr_q_i;
    unique case (cause_i)
      C_MMU: begin
        esr_o           = '0;
        esr_o[4]        = 1'b1;
        esr_o[1]        = miss_i;
        esr_o[0]        = (acc_i == ACC_FETCH);
        esr_o[ES_STORE] = (acc_i == ACC_STORE);
        esr_o[ES_DSLOT] = dslot_i;
      end
      C_HWEXC: esr_o[ES_DSLOT] = dslot_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter bit              EXC_EN  = 1'b1,
  parameter logic [XLEN-1:0] EXC_VEC = 'h20,
  parameter logic [XLEN-1:0] IRQ_VEC = 'h10,
  parameter logic [XLEN-1:0] BRK_VEC = 'h18
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [2:0]      cause_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] btarget_i,
  input  logic            dslot_i,
  input  logic            imm_i,
  input  logic            bimm_i,
  input  logic            fault_miss_i,
  input  logic [1:0]      fault_acc_i,
  input  logic [XLEN-1:0] fault_addr_i,
  input  logic [XLEN-1:0] msr_i,
  input  logic            mmu_ret_i,
  output logic            entry_o,
  output logic [XLEN-1:0] pc_o,
  output logic            link_we_o,
  output logic [LR_W-1:0] link_sel_o,
  output logic [XLEN-1:0] link_val_o,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] esr_o,
  output logic [XLEN-1:0] ear_o,
  output logic [XLEN-1:0] btr_o,
  output logic            flags_clr_o,
  output logic            fatal_o
);
  logic            cause_ok, hw_off, nested, take, fatal_d, is_exc;
  logic            mmu_pend_q;
  logic            lk_we;
  logic [LR_W-1:0] lk_sel;
  logic [XLEN-1:0] lk_val, msr_d, esr_d, pc_d;

  assign cause_ok = (cause_i <= C_SWBRK);
  assign hw_off   = (cause_i == C_HWEXC) && !EXC_EN;
  assign nested   = (cause_i == C_MMU) && mmu_pend_q;
  assign take     = req_i && cause_ok && !hw_off && !nested;
  assign fatal_d  = req_i && (!cause_ok || nested);
  assign is_exc   = (cause_i == C_HWEXC) || (cause_i == C_MMU);

  trap_link_calc #(.XLEN(XLEN)) u_link (
    .cause_i (cause_i),
    .pc_i    (pc_i),
    .dslot_i (dslot_i),
    .imm_i   (imm_i),
    .bimm_i  (bimm_i),
    .we_o    (lk_we),
    .sel_o   (lk_sel),
    .val_o   (lk_val)
  );

  trap_msr_calc #(.XLEN(XLEN)) u_msr (
    .cause_i (cause_i),
    .msr_i   (msr_i),
    .msr_o   (msr_d)
  );

  trap_esr_calc #(.XLEN(XLEN)) u_esr (
    .cause_i (cause_i),
    .esr_q_i (esr_o),
    .dslot_i (dslot_i),
    .miss_i  (fault_miss_i),
    .acc_i   (fault_acc_i),
    .esr_o   (esr_d)
  );

  always_comb begin
    unique case (cause_i)
      C_IRQ:   pc_d = IRQ_VEC;
      C_HWBRK: pc_d = BRK_VEC;
      C_SWBRK: pc_d = btarget_i;
      default: pc_d = EXC_VEC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_o     <= 1'b0;
      flags_clr_o <= 1'b0;
      fatal_o     <= 1'b0;
      link_we_o   <= 1'b0;
      link_sel_o  <= '0;
      link_val_o  <= '0;
      pc_o        <= '0;
      msr_o       <= '0;
      esr_o       <= '0;
      ear_o       <= '0;
      btr_o       <= '0;
      mmu_pend_q  <= 1'b0;
    end else begin
      entry_o     <= take;
      flags_clr_o <= take;
      fatal_o     <= fatal_d;
      link_we_o   <= take && lk_we;
      if (take) begin
        link_sel_o <= lk_sel;
        link_val_o <= lk_val;
        pc_o       <= pc_d;
        msr_o      <= msr_d;
        esr_o      <= esr_d;
        if (is_exc && dslot_i)    btr_o <= btarget_i;
        if (cause_i == C_MMU)     ear_o <= fault_addr_i;
      end
      if (take && cause_i == C_MMU) mmu_pend_q <= 1'b1;
      else if (mmu_ret_i)           mmu_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk
  import trap_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter bit              EXC_EN  = 1'b1,
  parameter logic [XLEN-1:0] EXC_VEC = 'h20,
  parameter logic [XLEN-1:0] IRQ_VEC = 'h10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [2:0]      cause_i,
  input logic            dslot_i,
  input logic [1:0]      fault_acc_i,
  input logic            mmu_pend_q,
  input logic            entry_o,
  input logic            link_we_o,
  input logic            flags_clr_o,
  input logic            fatal_o,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] msr_o,
  input logic [XLEN-1:0] esr_o
);
  AST_ENTRY_MODE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> (!msr_o[ST_VM] && !msr_o[ST_UM])); // R5

  AST_HWEXC_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cause_i == C_HWEXC && EXC_EN) |=> (entry_o && msr_o[ST_EIP] && pc_o == EXC_VEC)); // R2

  AST_IRQ_IE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cause_i == C_IRQ) |=> (entry_o && !msr_o[ST_IE] && pc_o == IRQ_VEC)); // R6

  AST_MMU_STORE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cause_i == C_MMU && !mmu_pend_q && fault_acc_i == ACC_STORE)
      |=> (esr_o[ES_STORE] && esr_o[4])); // R9

  AST_DSLOT_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ((cause_i == C_HWEXC && EXC_EN) || (cause_i == C_MMU && !mmu_pend_q)))
      |=> (esr_o[ES_DSLOT] == $past(dslot_i))); // R4

  AST_NESTED_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cause_i == C_MMU && mmu_pend_q) |=> (fatal_o && !entry_o && $stable(pc_o))); // R10

  AST_HWEXC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cause_i == C_HWEXC && !EXC_EN) |=> (!entry_o && !fatal_o)); // R11

  AST_FATAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> (!entry_o && !link_we_o && !flags_clr_o)); // R12

  AST_PULSE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_clr_o || link_we_o) |-> entry_o); // R13
endmodule

bind trap_entry_seq trap_entry_seq_chk #(
  .XLEN(XLEN), .EXC_EN(EXC_EN), .EXC_VEC(EXC_VEC), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .cause_i     (cause_i),
  .dslot_i     (dslot_i),
  .fault_acc_i (fault_acc_i),
  .mmu_pend_q  (mmu_pend_q),
  .entry_o     (entry_o),
  .link_we_o   (link_we_o),
  .flags_clr_o (flags_clr_o),
  .fatal_o     (fatal_o),
  .pc_o        (pc_o),
  .msr_o       (msr_o),
  .esr_o       (esr_o)
);

// File: tb/trap_entry_seq_bench.sv
module trap_entry_seq_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  cause;
    logic [31:0] pc;
    logic        ds;
    logic        im;
    logic        bi;
    logic [31:0] msr;
    logic [31:0] epc;
    logic        ewe;
    logic [4:0]  esel;
    logic [31:0] elink;
    logic [31:0] emsr;
  } vec_t;

  // cause, pc, ds, im, bi, msr_in, exp pc, exp we, exp sel, exp link, exp msr
  localparam vec_t VECS [10] = '{
    '{3'd0, 32'h100, 1'b0, 1'b0, 1'b0, 32'h2802, 32'h20,   1'b1, 5'd17, 32'h104, 32'h5202},
    '{3'd1, 32'h200, 1'b0, 1'b0, 1'b0, 32'h2000, 32'h20,   1'b1, 5'd17, 32'h200, 32'h4200},
    '{3'd1, 32'h300, 1'b1, 1'b0, 1'b0, 32'h0000, 32'h20,   1'b1, 5'd17, 32'h2FC, 32'h0200},
    '{3'd1, 32'h400, 1'b1, 1'b0, 1'b1, 32'h0800, 32'h20,   1'b1, 5'd17, 32'h3F8, 32'h1200},
    '{3'd1, 32'h500, 1'b0, 1'b1, 1'b0, 32'h0000, 32'h20,   1'b1, 5'd17, 32'h4FC, 32'h0200},
    '{3'd1, 32'h600, 1'b0, 1'b1, 1'b1, 32'h0000, 32'h20,   1'b1, 5'd17, 32'h5FC, 32'h0200},
    '{3'd2, 32'h700, 1'b0, 1'b0, 1'b0, 32'h2802, 32'h10,   1'b1, 5'd14, 32'h700, 32'h5000},
    '{3'd3, 32'h800, 1'b0, 1'b0, 1'b0, 32'h0002, 32'h18,   1'b1, 5'd16, 32'h800, 32'h000A},
    '{3'd4, 32'h900, 1'b0, 1'b0, 1'b0, 32'h2000, 32'h1234, 1'b0, 5'd0,  32'h0,   32'h4008},
    '{3'd2, 32'hA00, 1'b0, 1'b0, 1'b0, 32'h0202, 32'h10,   1'b1, 5'd14, 32'hA00, 32'h0200}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_nx = 1'b0;
  logic [2:0]  cause = '0;
  logic [31:0] pc = '0, bt = '0, addr = '0, msr = '0;
  logic        ds = 1'b0, im = 1'b0, bi = 1'b0, miss = 1'b0, ret = 1'b0;
  logic [1:0]  acc = '0;

  logic        entry, lwe, fclr, fatal;
  logic [4:0]  lsel;
  logic [31:0] pc_q, lval, msr_q, esr_q, ear_q, btr_q;
  logic        entry_nx, lwe_nx, fclr_nx, fatal_nx;
  logic [4:0]  lsel_nx;
  logic [31:0] pc_nx, lval_nx, msr_nx, esr_nx, ear_nx, btr_nx;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trap_entry_seq u_trap_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cause_i(cause), .pc_i(pc),
    .btarget_i(bt), .dslot_i(ds), .imm_i(im), .bimm_i(bi), .fault_miss_i(miss),
    .fault_acc_i(acc), .fault_addr_i(addr), .msr_i(msr), .mmu_ret_i(ret),
    .entry_o(entry), .pc_o(pc_q), .link_we_o(lwe), .link_sel_o(lsel),
    .link_val_o(lval), .msr_o(msr_q), .esr_o(esr_q), .ear_o(ear_q),
    .btr_o(btr_q), .flags_clr_o(fclr), .fatal_o(fatal)
  );

  trap_entry_seq #(.EXC_EN(1'b0)) u_trap_entry_seq_noexc (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_nx), .cause_i(cause), .pc_i(pc),
    .btarget_i(bt), .dslot_i(ds), .imm_i(im), .bimm_i(bi), .fault_miss_i(miss),
    .fault_acc_i(acc), .fault_addr_i(addr), .msr_i(msr), .mmu_ret_i(ret),
    .entry_o(entry_nx), .pc_o(pc_nx), .link_we_o(lwe_nx), .link_sel_o(lsel_nx),
    .link_val_o(lval_nx), .msr_o(msr_nx), .esr_o(esr_nx), .ear_o(ear_nx),
    .btr_o(btr_nx), .flags_clr_o(fclr_nx), .fatal_o(fatal_nx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // request applied at a falling edge, results checked at the next falling edge
  task automatic fire(input logic [2:0] c, input logic [31:0] p, input logic [31:0] b,
                      input logic d, input logic i, input logic bb, input logic ms,
                      input logic [1:0] a, input logic [31:0] ad, input logic [31:0] m,
                      input logic nx);
    @(negedge clk);
    cause = c; pc = p; bt = b; ds = d; im = i; bi = bb;
    miss = ms; acc = a; addr = ad; msr = m;
    if (nx) req_nx = 1'b1; else req = 1'b1;
    @(negedge clk);
    req = 1'b0; req_nx = 1'b0;
  endtask

  task automatic mmu_done();
    @(negedge clk);
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 values during reset
    chk("R1 pc in reset", pc_q, 32'h0);
    chk("R1 msr in reset", msr_q, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc", pc_q, 32'h0);
    chk("R1 msr", msr_q, 32'h0);
    chk("R1 esr", esr_q, 32'h0);
    chk("R1 ear", ear_q, 32'h0);
    chk("R1 btr", btr_q, 32'h0);
    chk("R1 link", {lval[26:0], lsel}, 32'h0);
    chk("R1 pulses", {28'h0, entry, lwe, fclr, fatal}, 32'h0);

    for (int k = 0; k < 10; k++) begin
      fire(VECS[k].cause, VECS[k].pc, 32'h1234, VECS[k].ds, VECS[k].im, VECS[k].bi,
           1'b0, 2'd0, 32'h0, VECS[k].msr, 1'b0);
      chk("R2/R3/R6/R7/R8 new pc", pc_q, VECS[k].epc);
      chk("R13 entry and flag clear", {30'h0, entry, fclr}, 32'h3);
      chk("R8 link write enable", {31'h0, lwe}, {31'h0, VECS[k].ewe});
      if (VECS[k].ewe) begin
        chk("R2/R3/R6/R7 link index", {27'h0, lsel}, {27'h0, VECS[k].esel});
        chk("R2/R3/R6/R7 link value", lval, VECS[k].elink);
      end
      chk("R5 status word", msr_q, VECS[k].emsr);
      @(negedge clk);
      chk("R13 entry pulse width", {31'h0, entry}, 32'h0);
      mmu_done();
    end

    // R9 codes: load protection, fetch protection
    fire(3'd1, 32'h40, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'hDEAD0000, 32'h0, 1'b0);
    chk("R9 load protection code", esr_q, 32'h10);
    chk("R9 fault address", ear_q, 32'hDEAD0000);
    mmu_done();
    fire(3'd1, 32'h40, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0BAD0000, 32'h0, 1'b0);
    chk("R9 fetch protection code", esr_q, 32'h11);
    mmu_done();
    // R9 store miss in delay slot, R4 branch target capture
    fire(3'd1, 32'h80, 32'hCAFE0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 32'h00F00D00, 32'h0, 1'b0);
    chk("R9 store miss code with R4 bit", esr_q, 32'h1412);
    chk("R4 branch target", btr_q, 32'hCAFE0);
    chk("R9 store miss address", ear_q, 32'h00F00D00);
    // R10 nested fault without return pulse
    fire(3'd1, 32'h90, 32'h7777, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h5555, 32'h2000, 1'b0);
    chk("R10 fatal", {31'h0, fatal}, 32'h1);
    chk("R10 no entry", {31'h0, entry}, 32'h0);
    chk("R10 ear held", ear_q, 32'h00F00D00);
    chk("R10 esr held", esr_q, 32'h1412);
    chk("R10 msr held", msr_q, 32'h0200);
    mmu_done();
    fire(3'd1, 32'hA0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 32'h1000, 32'h0, 1'b0);
    chk("R9 fetch miss code", esr_q, 32'h13);
    chk("R10 fault accepted after return", {31'h0, entry}, 32'h1);
    mmu_done();

    // R4 hardware exception sets then clears the delay-slot bit
    fire(3'd0, 32'hB0, 32'hB0B0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0);
    chk("R4 hw exc delay-slot bit", esr_q, 32'h1013);
    chk("R4 hw exc branch target", btr_q, 32'hB0B0);
    fire(3'd0, 32'hC0, 32'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0);
    chk("R4 hw exc bit cleared", esr_q, 32'h13);
    chk("R4 branch target held", btr_q, 32'hB0B0);
    chk("R2 link after hw exc", lval, 32'hC4);

    // R12 unknown cause
    fire(3'd5, 32'hD0, 32'h4444, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h9999, 32'h2802, 1'b0);
    chk("R12 fatal", {31'h0, fatal}, 32'h1);
    chk("R12 no entry", {30'h0, entry, lwe}, 32'h0);
    chk("R12 pc held", pc_q, 32'h20);
    chk("R12 msr held", msr_q, 32'h0200);
    chk("R12 btr held", btr_q, 32'hB0B0);

    // R11 exception support off
    fire(3'd0, 32'hE0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h2802, 1'b1);
    chk("R11 no entry", {30'h0, entry_nx, fatal_nx}, 32'h0);
    chk("R11 pc unchanged", pc_nx, 32'h0);
    chk("R11 status unchanged", msr_nx, 32'h0);
    chk("R11 esr unchanged", esr_nx, 32'h0);
    fire(3'd2, 32'hF0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0002, 1'b1);
    chk("R11 other causes still taken", pc_nx, 32'h10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule